// File: doc/BRIEF.md
# Dual-Modulus Fractional Tick Divider

This block derives a low-rate enable strobe from a single fast input clock when the wanted ratio is not a whole number. The target case is a 6.144 MHz clock and a tick of about 1 MHz. The core counter divides by either 6 or 7, and it chooses between them once for each output period. A step accumulator spreads the long periods evenly through a frame of 40 output periods. Six periods in each frame are long and thirty-four are short. The average ratio is therefore 246/40 = 6.15. That gives about 0.99902 MHz, an error of roughly 0.098 %.

Every register runs on the one input clock, and no derived clock exists. Downstream logic uses `tick_o` as a clock enable. A frame counter advances once per tick. When it wraps, it forces the accumulator back to its start value, so the pattern restarts at the same phase in every frame. A synchronous reset clears the modulus counter, the accumulator and the frame counter together.

Top module: `frac_tick_div`

## Requirements
- R1: While `srst_i` is high at a rising edge, every counter returns to zero and `tick_o` is low. After `srst_i` is sampled low, the first `tick_o` is high after exactly 5 rising edges, because period 0 is a short period that counts from the release cycle.
- R2: `tick_o` is high for exactly one clock cycle at a time. It is never high in two consecutive cycles.
- R3: After the first tick, the gap between consecutive rising edges of `tick_o` is always either 6 or 7 clock cycles.
- R4: Output periods are numbered k = 0, 1, 2, ... from the last reset, and period k is the one that ends with tick k. Period k is long (7 cycles) exactly when floor((k+1)*6/40) > floor(k*6/40), and short (6 cycles) otherwise. The first long period is therefore k = 6.
- R5: Every frame of 40 consecutive periods starting at k = 40*m contains exactly 6 long periods. Its gaps add up to exactly 246 clock cycles.
- R6: Long periods are spread through the frame. Between any two long periods there are at least 5 short periods.
- R7: A reset asserted in the middle of a period or a frame restarts the sequence. After release, the behaviour of R1 and R4 repeats from period 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | The single input clock. Every register uses it. |
| srst_i | input | 1 | Synchronous reset, active high. |
| tick_o | output | 1 | One-cycle enable strobe at the end of each output period. |

## Verification
The hardest situation to reach is the frame boundary. It lies 246 cycles after reset, and there the accumulator must land on zero just as the frame counter forces it there. A fault in either piece shows up only as a wrong gap pattern one frame later. The bench therefore records two full frames of gaps and compares each one with the floor formula. It then asserts reset in the middle of a period, in the middle of the sequence, to show that the restart phase is exact.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // A period is long when adding the step carries past the frame length.
  function automatic logic is_long(int acc, int step, int frame);
    return (acc + step) >= frame;
  endfunction

  // Accumulator value after one period, kept modulo the frame length.
  function automatic int acc_next(int acc, int step, int frame);
    if (is_long(acc, step, frame)) begin
      return acc + step - frame;
    end
    return acc + step;
  endfunction

  // Terminal count of the modulus counter for the current period.
  function automatic int term_value(int short_div, logic long_sel);
    return long_sel ? short_div : short_div - 1;
  endfunction

endpackage

// File: rtl/fdiv_mod_counter.sv
module fdiv_mod_counter #(
  parameter int SHORT_DIV = 6
) (
  input  logic clk_i,
  input  logic srst_i,
  input  logic long_sel_i,
  output logic terminal_o
);
  localparam int CNT_W = $clog2(SHORT_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit      = CNT_W'(fdiv_pkg::term_value(SHORT_DIV, long_sel_i));
  assign terminal_o = (cnt_q == limit);

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      cnt_q <= '0;
    end else if (terminal_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fdiv_step_accum.sv
module fdiv_step_accum #(
  parameter int FRAME_LEN      = 40,
  parameter int LONG_PER_FRAME = 6
) (
  input  logic                         clk_i,
  input  logic                         srst_i,
  input  logic                         advance_i,
  input  logic                         restart_i,
  output logic                         long_sel_o,
  output logic [$clog2(FRAME_LEN)-1:0] acc_step_o
);
  localparam int ACC_W = $clog2(FRAME_LEN);

  logic [ACC_W-1:0] acc_q;

  assign long_sel_o = fdiv_pkg::is_long(int'(acc_q), LONG_PER_FRAME, FRAME_LEN);
  assign acc_step_o = ACC_W'(fdiv_pkg::acc_next(int'(acc_q), LONG_PER_FRAME, FRAME_LEN));

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      acc_q <= '0;
    end else if (advance_i) begin
      acc_q <= restart_i ? '0 : acc_step_o;
    end
  end
endmodule

// File: rtl/fdiv_frame_counter.sv
module fdiv_frame_counter #(
  parameter int FRAME_LEN = 40
) (
  input  logic clk_i,
  input  logic srst_i,
  input  logic advance_i,
  output logic frame_wrap_o
);
  localparam int FRM_W = $clog2(FRAME_LEN);
  localparam logic [FRM_W-1:0] LAST = FRM_W'(FRAME_LEN - 1);

  logic [FRM_W-1:0] frm_q;

  assign frame_wrap_o = advance_i && (frm_q == LAST);

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      frm_q <= '0;
    end else if (advance_i) begin
      frm_q <= frame_wrap_o ? '0 : frm_q + 1'b1;
    end
  end
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div #(
  parameter int SHORT_DIV      = 6,
  parameter int FRAME_LEN      = 40,
  parameter int LONG_PER_FRAME = 6
) (
  input  logic clk_i,
  input  logic srst_i,
  output logic tick_o
);
  localparam int ACC_W = $clog2(FRAME_LEN);

  // Named internal events, observed by the bound checker.
  logic             terminal;
  logic             long_sel;
  logic             frame_wrap;
  logic [ACC_W-1:0] acc_step;

  fdiv_mod_counter #(.SHORT_DIV(SHORT_DIV)) mod_cnt_i (
    .clk_i      (clk_i),
    .srst_i     (srst_i),
    .long_sel_i (long_sel),
    .terminal_o (terminal)
  );

  fdiv_step_accum #(
    .FRAME_LEN      (FRAME_LEN),
    .LONG_PER_FRAME (LONG_PER_FRAME)
  ) accum_i (
    .clk_i      (clk_i),
    .srst_i     (srst_i),
    .advance_i  (terminal),
    .restart_i  (frame_wrap),
    .long_sel_o (long_sel),
    .acc_step_o (acc_step)
  );

  fdiv_frame_counter #(.FRAME_LEN(FRAME_LEN)) frame_i (
    .clk_i        (clk_i),
    .srst_i       (srst_i),
    .advance_i    (terminal),
    .frame_wrap_o (frame_wrap)
  );

  assign tick_o = terminal && !srst_i;
endmodule

// File: rtl/frac_tick_div_chk.sv
module frac_tick_div_chk #(
  parameter int SHORT_DIV      = 6,
  parameter int FRAME_LEN      = 40,
  parameter int LONG_PER_FRAME = 6
) (
  input logic                         clk_i,
  input logic                         srst_i,
  input logic                         tick_o,
  input logic                         terminal,
  input logic                         long_sel,
  input logic                         frame_wrap,
  input logic [$clog2(FRAME_LEN)-1:0] acc_step
);
  localparam int GAP_W = $clog2(SHORT_DIV + 3);
  localparam int LC_W  = $clog2(FRAME_LEN + 1);
  localparam int RUN_W = $clog2(FRAME_LEN + 1);

  logic [GAP_W-1:0] since_q;
  logic             seen_tick_q;
  logic [LC_W-1:0]  long_cnt_q;
  logic [RUN_W-1:0] short_run_q;
  logic             seen_long_q;

  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      since_q     <= '0;
      seen_tick_q <= 1'b0;
      long_cnt_q  <= '0;
      short_run_q <= '0;
      seen_long_q <= 1'b0;
    end else begin
      if (tick_o) begin
        since_q     <= '0;
        seen_tick_q <= 1'b1;
      end else if (since_q != {GAP_W{1'b1}}) begin
        since_q <= since_q + 1'b1;
      end
      if (terminal) begin
        if (frame_wrap) begin
          long_cnt_q <= '0;
        end else if (long_sel) begin
          long_cnt_q <= long_cnt_q + 1'b1;
        end
        if (long_sel) begin
          short_run_q <= '0;
          seen_long_q <= 1'b1;
        end else if (short_run_q != {RUN_W{1'b1}}) begin
          short_run_q <= short_run_q + 1'b1;
        end
      end
    end
  end

  // R1: the cycle after reset is released never carries a tick
  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (srst_i)
    $past(srst_i) |-> !tick_o);

  // R2: strobe is one cycle wide
  p_single_tick_r2: assert property (@(posedge clk_i) disable iff (srst_i)
    tick_o |=> !tick_o);

  // R3: gap between ticks is the short or the long modulus
  p_gap_bounds_r3: assert property (@(posedge clk_i) disable iff (srst_i)
    (tick_o && seen_tick_q) |->
      ((since_q == GAP_W'(SHORT_DIV - 1)) || (since_q == GAP_W'(SHORT_DIV))));

  // R5: accumulator arithmetic closes the frame exactly at zero
  p_frame_closes_r5: assert property (@(posedge clk_i) disable iff (srst_i)
    frame_wrap |-> (acc_step == '0));

  // R5: each frame holds the stated number of long periods
  p_long_count_r5: assert property (@(posedge clk_i) disable iff (srst_i)
    frame_wrap |->
      ((long_cnt_q + LC_W'(long_sel)) == LC_W'(LONG_PER_FRAME)));

  // R6: long periods are separated by at least five short ones
  p_long_spread_r6: assert property (@(posedge clk_i) disable iff (srst_i)
    (terminal && long_sel && seen_long_q) |-> (short_run_q >= RUN_W'(5)));
endmodule

bind frac_tick_div frac_tick_div_chk #(
  .SHORT_DIV      (SHORT_DIV),
  .FRAME_LEN      (FRAME_LEN),
  .LONG_PER_FRAME (LONG_PER_FRAME)
) chk_i (
  .clk_i      (clk_i),
  .srst_i     (srst_i),
  .tick_o     (tick_o),
  .terminal   (terminal),
  .long_sel   (long_sel),
  .frame_wrap (frame_wrap),
  .acc_step   (acc_step)
);

// File: tb/frac_tick_div_tb_top.sv
module frac_tick_div_tb_top;
  logic clk_i = 1'b0;
  logic srst_i = 1'b1;
  logic tick_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  frac_tick_div dut_i (.clk_i(clk_i), .srst_i(srst_i), .tick_o(tick_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Long-period rule, restated from the floor formula.
  function automatic int exp_gap(int k);
    return (((k + 1) * 6) / 40 > (k * 6) / 40) ? 7 : 6;
  endfunction

  // Counts negedges until tick_o is seen high; also checks strobe width.
  task automatic wait_tick(output int n);
    n = 0;
    forever begin
      @(negedge clk_i);
      n++;
      if (tick_o) break;
      if (n > 50) break;
    end
    @(negedge clk_i);
    check(!tick_o, "R2 tick width", int'(tick_o), 0);
    n = n; // the extra negedge is accounted for by the caller
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk_i);
    srst_i = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      check(!tick_o, "R1 low in reset", int'(tick_o), 0);
    end
    srst_i = 1'b0;
  endtask

  // Collects gaps for periods 0..count-1; gap 0 is counted from release.
  task automatic run_periods(input int count, input string tag);
    int g, sum_a, sum_b, longs_a, longs_b, last_long, prev_long;
    int extra;
    sum_a = 0; sum_b = 0; longs_a = 0; longs_b = 0; prev_long = -1;
    extra = 0;
    for (int k = 0; k < count; k++) begin
      wait_tick(g);
      g = g + extra;
      extra = 1;  // wait_tick consumed one negedge past the tick
      if (k == 0) begin
        check(g == 5, {tag, " R1 first tick"}, g, 5);
      end else begin
        check(g == exp_gap(k), {tag, " R4 period gap"}, g, exp_gap(k));
        check(g == 6 || g == 7, {tag, " R3 gap range"}, g, 6);
      end
      if (k < 40) begin
        sum_a += (k == 0) ? 6 : g;
        if (g == 7) longs_a++;
      end else if (k < 80) begin
        sum_b += g;
        if (g == 7) longs_b++;
      end
      if (g == 7) begin
        last_long = k;
        if (prev_long >= 0)
          check(last_long - prev_long >= 6, {tag, " R6 spread"},
                last_long - prev_long - 1, 5);
        prev_long = last_long;
      end
    end
    if (count >= 40) begin
      check(sum_a == 246, {tag, " R5 frame0 cycles"}, sum_a, 246);
      check(longs_a == 6, {tag, " R5 frame0 longs"}, longs_a, 6);
    end
    if (count >= 80) begin
      check(sum_b == 246, {tag, " R5 frame1 cycles"}, sum_b, 246);
      check(longs_b == 6, {tag, " R5 frame1 longs"}, longs_b, 6);
    end
  endtask

  task automatic t_reset_state();
    do_reset(4);
  endtask

  task automatic t_two_frames();
    run_periods(85, "main");
  endtask

  task automatic t_mid_reset();
    // let a few periods run, then reset in the middle of one (R7)
    repeat (23) @(negedge clk_i);
    do_reset(3);
    run_periods(15, "R7 restart");
  endtask

  initial begin
    t_reset_state();
    t_two_frames();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule